// File: doc/BRIEF.md
# Peak-Tracking Offset Calculator

This block watches a stream of signed samples of a differential signal. It finds the turning points of each signal period, a local maximum and a local minimum, and keeps the most recent one of each. From those two values it forms an offset estimate. The estimate is their arithmetic mean, limited to the range of the correction converter. The result is an offset correction word that a digital-to-analog converter subtracts ahead of the sampling converter. A turning point counts only once the signal has moved away from it by more than a digital noise constant. This keeps small ripple from being taken as an extreme. The noise constant is one of two input values, and a gain-state input picks which one.

The block starts out uncalibrated. It issues its first correction as soon as both kinds of extreme are known, which needs only two signal transitions, and from then on it reports itself calibrated. In calibrated mode a new estimate is applied only when its sign of change agrees with the slope just entered: increases on a rising slope, decreases on a falling slope. This keeps a single distorted half-period from dragging the correction the wrong way. A registered slope bit gives the current signal direction. An update strobe marks every cycle in which the correction word takes a new value. Corrections are computed on their own schedule and do not wait on any output switching.

Top module: `ptoc_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, the correction word is 0 and the update strobe, the calibrated flag and the slope bit are all 0.
- R2: A turning point, or the first departure from the starting band, is recognised only when the sample lies strictly more than the selected noise constant beyond the running extreme. A difference equal to the constant is not enough.
- R3: With the gain select at 0 the low noise constant applies, and with it at 1 the high noise constant applies.
- R4: The slope bit reads 1 for a rising and 0 for a falling signal. It takes its new value in the cycle after the sample that confirms an extreme, or after the sample that first leaves the starting band.
- R5: The candidate correction is floor((max + min) / 2) of the latest confirmed maximum and minimum, clamped to the signed range of the correction word (-512 to 511 at default widths).
- R6: No correction is issued until at least one maximum and one minimum have both been confirmed.
- R7: The first correction is applied whatever its value, and it sets the calibrated flag. The flag then stays at 1 until reset.
- R8: When calibrated, a correction confirmed at a minimum (entering a rising slope) is applied only if it is larger than the current word. One confirmed at a maximum (entering a falling slope) is applied only if it is smaller. An equal value is not applied.
- R9: The update strobe is 1 for exactly one cycle, two clock edges after the confirming sample edge. The correction word changes only in a cycle where the strobe is 1.
- R10: Samples presented while the valid strobe is 0 change neither the outputs nor the running extremes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp | input | 12 | Signed two's-complement sample |
| noise_lo | input | 8 | Unsigned noise constant for gain select 0 |
| noise_hi | input | 8 | Unsigned noise constant for gain select 1 |
| gain_sel | input | 1 | Picks which noise constant applies |
| ofs_word | output | 10 | Signed offset correction word |
| ofs_upd | output | 1 | One-cycle strobe on a new correction word |
| calibrated | output | 1 | Set after the first correction |
| slope_up | output | 1 | Current signal direction, 1 for rising |

## Verification
The assertions assume that the sample and the gain select are steady whenever the valid strobe is high. They also assume that the noise constants do not change in the middle of a half-period in a way that would matter. The stimulus changes inputs only on falling clock edges. It follows every valid sample with one idle cycle, so each confirmation lets its strobe settle before the next sample arrives. The sample sequences are chosen so that every direction gate is hit in both its pass and block outcomes. They also hit clamping at both ends of the range and a threshold difference exactly equal to the noise constant.

// File: rtl/ptoc_pkg.sv
package ptoc_pkg;
    // Tracker phase: waiting for first sample, inside the start band,
    // or following a rising / falling half-period.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_RISE  = 2'd2,
        PH_FALL  = 2'd3
    } phase_e;
endpackage

// File: rtl/ptoc_peak_track.sv
module ptoc_peak_track
    import ptoc_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int NZ_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [NZ_W-1:0]         noise_lo,
    input  logic [NZ_W-1:0]         noise_hi,
    input  logic                    gain_sel,
    output logic                    evt,
    output logic                    evt_max,
    output logic signed [SMP_W-1:0] evt_val,
    output logic                    slope_up
);
    localparam int EXT_W = (SMP_W > NZ_W ? SMP_W : NZ_W) + 2;

    typedef struct packed {
        phase_e                  phase;
        logic signed [SMP_W-1:0] run_hi;
        logic signed [SMP_W-1:0] run_lo;
        logic                    evt;
        logic                    evt_max;
        logic signed [SMP_W-1:0] evt_val;
        logic                    slope;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [NZ_W-1:0]         nz_sel;
    logic signed [EXT_W-1:0] nz_x, s_x, rise_amt, fall_amt;

    always_comb begin
        nz_sel   = gain_sel ? noise_hi : noise_lo;
        nz_x     = signed'({{(EXT_W-NZ_W){1'b0}}, nz_sel});
        s_x      = EXT_W'(smp);
        rise_amt = s_x - EXT_W'(trk_q.run_lo);
        fall_amt = EXT_W'(trk_q.run_hi) - s_x;

        trk_d     = trk_q;
        trk_d.evt = 1'b0;
        if (smp_vld) begin
            case (trk_q.phase)
                PH_IDLE: begin
                    trk_d.run_hi = smp;
                    trk_d.run_lo = smp;
                    trk_d.phase  = PH_START;
                end
                PH_START: begin
                    if (rise_amt > nz_x) begin
                        trk_d.phase  = PH_RISE;
                        trk_d.slope  = 1'b1;
                        trk_d.run_hi = smp;
                    end else if (fall_amt > nz_x) begin
                        trk_d.phase  = PH_FALL;
                        trk_d.slope  = 1'b0;
                        trk_d.run_lo = smp;
                    end else begin
                        if (smp > trk_q.run_hi) trk_d.run_hi = smp;
                        if (smp < trk_q.run_lo) trk_d.run_lo = smp;
                    end
                end
                PH_RISE: begin
                    if (smp > trk_q.run_hi) begin
                        trk_d.run_hi = smp;
                    end else if (fall_amt > nz_x) begin
                        trk_d.evt     = 1'b1;
                        trk_d.evt_max = 1'b1;
                        trk_d.evt_val = trk_q.run_hi;
                        trk_d.phase   = PH_FALL;
                        trk_d.slope   = 1'b0;
                        trk_d.run_lo  = smp;
                    end
                end
                default: begin
                    if (smp < trk_q.run_lo) begin
                        trk_d.run_lo = smp;
                    end else if (rise_amt > nz_x) begin
                        trk_d.evt     = 1'b1;
                        trk_d.evt_max = 1'b0;
                        trk_d.evt_val = trk_q.run_lo;
                        trk_d.phase   = PH_RISE;
                        trk_d.slope   = 1'b1;
                        trk_d.run_hi  = smp;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign evt      = trk_q.evt;
    assign evt_max  = trk_q.evt_max;
    assign evt_val  = trk_q.evt_val;
    assign slope_up = trk_q.slope;

    // R10
    idle_keeps_slope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(slope_up));
    // R10
    idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !evt);
    // R4
    event_sets_slope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (slope_up == !evt_max));
endmodule

// File: rtl/ptoc_ofs_calc.sv
module ptoc_ofs_calc #(
    parameter int SMP_W = 12,
    parameter int OFS_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt,
    input  logic                    evt_max,
    input  logic signed [SMP_W-1:0] evt_val,
    output logic signed [OFS_W-1:0] ofs_word,
    output logic                    ofs_upd,
    output logic                    calibrated
);
    typedef struct packed {
        logic signed [SMP_W-1:0] hi;
        logic signed [SMP_W-1:0] lo;
        logic                    have_hi;
        logic                    have_lo;
        logic signed [OFS_W-1:0] ofs;
        logic                    upd;
        logic                    cal;
    } calc_t;

    calc_t calc_d, calc_q;

    logic signed [SMP_W-1:0] hi_n, lo_n, mean;
    logic signed [SMP_W:0]   sum;
    logic signed [OFS_W-1:0] cand;

    always_comb begin
        hi_n = (evt &&  evt_max) ? evt_val : calc_q.hi;
        lo_n = (evt && !evt_max) ? evt_val : calc_q.lo;
        sum  = (SMP_W+1)'(hi_n) + (SMP_W+1)'(lo_n);
        mean = SMP_W'(sum >>> 1);
    end

    generate
        if (OFS_W < SMP_W) begin : g_clamp
            localparam logic signed [SMP_W-1:0] OFS_MAX = SMP_W'((1 << (OFS_W-1)) - 1);
            localparam logic signed [SMP_W-1:0] OFS_MIN = SMP_W'(-(1 << (OFS_W-1)));
            always_comb begin
                if (mean > OFS_MAX)      cand = OFS_MAX[OFS_W-1:0];
                else if (mean < OFS_MIN) cand = OFS_MIN[OFS_W-1:0];
                else                     cand = mean[OFS_W-1:0];
            end
        end else begin : g_extend
            always_comb cand = OFS_W'(mean);
        end
    endgenerate

    always_comb begin
        calc_d     = calc_q;
        calc_d.upd = 1'b0;
        if (evt) begin
            calc_d.hi = hi_n;
            calc_d.lo = lo_n;
            if (evt_max) calc_d.have_hi = 1'b1;
            else         calc_d.have_lo = 1'b1;
            if (calc_d.have_hi && calc_d.have_lo) begin
                if (!calc_q.cal) begin
                    calc_d.ofs = cand;
                    calc_d.upd = 1'b1;
                    calc_d.cal = 1'b1;
                end else if (( evt_max && cand < calc_q.ofs) ||
                             (!evt_max && cand > calc_q.ofs)) begin
                    calc_d.ofs = cand;
                    calc_d.upd = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) calc_q <= '0;
        else        calc_q <= calc_d;
    end

    assign ofs_word   = calc_q.ofs;
    assign ofs_upd    = calc_q.upd;
    assign calibrated = calc_q.cal;

    // R7
    cal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        calibrated |=> calibrated);
    // R9
    word_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs_upd |-> $stable(ofs_word));
    // R8
    falling_only_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && evt_max && calibrated) |=> (!ofs_upd || ofs_word < $past(ofs_word)));
    // R8
    rising_only_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !evt_max && calibrated) |=> (!ofs_upd || ofs_word > $past(ofs_word)));
endmodule

// File: rtl/ptoc_top.sv
module ptoc_top #(
    parameter int SMP_W = 12,
    parameter int NZ_W  = 8,
    parameter int OFS_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [NZ_W-1:0]         noise_lo,
    input  logic [NZ_W-1:0]         noise_hi,
    input  logic                    gain_sel,
    output logic signed [OFS_W-1:0] ofs_word,
    output logic                    ofs_upd,
    output logic                    calibrated,
    output logic                    slope_up
);
    logic                    evt, evt_max;
    logic signed [SMP_W-1:0] evt_val;

    ptoc_peak_track #(.SMP_W(SMP_W), .NZ_W(NZ_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp      (smp),
        .noise_lo (noise_lo),
        .noise_hi (noise_hi),
        .gain_sel (gain_sel),
        .evt      (evt),
        .evt_max  (evt_max),
        .evt_val  (evt_val),
        .slope_up (slope_up)
    );

    ptoc_ofs_calc #(.SMP_W(SMP_W), .OFS_W(OFS_W)) u_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .evt_max    (evt_max),
        .evt_val    (evt_val),
        .ofs_word   (ofs_word),
        .ofs_upd    (ofs_upd),
        .calibrated (calibrated)
    );

    // R9
    strobe_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> !ofs_upd);
    // R7
    strobe_leaves_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_upd |-> calibrated);
endmodule

// File: tb/tb_ptoc_top.sv
module tb_ptoc_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 31;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [11:0] smp = '0;
    logic [7:0]         noise_lo = 8'd10;
    logic [7:0]         noise_hi = 8'd20;
    logic               gain_sel = 1'b0;
    logic signed [9:0]  ofs_word;
    logic               ofs_upd, calibrated, slope_up;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptoc_top dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
        .noise_lo(noise_lo), .noise_hi(noise_hi), .gain_sel(gain_sel),
        .ofs_word(ofs_word), .ofs_upd(ofs_upd), .calibrated(calibrated),
        .slope_up(slope_up)
    );

    // {gain, sample, slope, strobe, calibrated, word}
    function automatic logic [25:0] mk(int g, int s, int sl, int up, int c, int o);
        return {1'(g), 12'(s), 1'(sl), 1'(up), 1'(c), 10'(o)};
    endfunction

    localparam logic [25:0] TBL [NVEC] = '{
        mk(0,     0, 0, 0, 0,    0),  // prime
        mk(0,    10, 0, 0, 0,    0),  // R2 equal to noise: no departure
        mk(0,    11, 1, 0, 0,    0),  // R2 R4 departs upward
        mk(0,   100, 1, 0, 0,    0),
        mk(0,    95, 1, 0, 0,    0),
        mk(0,    89, 0, 0, 0,    0),  // R6 max 100 only
        mk(0,   -60, 0, 0, 0,    0),
        mk(0,   -49, 1, 1, 1,   20),  // R7 first correction
        mk(0,   120, 1, 0, 1,   20),
        mk(0,   109, 0, 0, 1,   20),  // R8 up on falling blocked
        mk(0,  -100, 0, 0, 1,   20),
        mk(0,   -89, 1, 0, 1,   20),  // R8 down on rising blocked
        mk(0,    50, 1, 0, 1,   20),
        mk(0,    39, 0, 1, 1,  -25),  // R8 down on falling
        mk(0,   -10, 0, 0, 1,  -25),
        mk(0,     5, 1, 1, 1,   20),  // R8 up on rising
        mk(1,    25, 1, 0, 1,   20),
        mk(1,    10, 1, 0, 1,   20),  // R3 15 below peak, high noise
        mk(1,     4, 0, 1, 1,    7),  // R5 floor of 15/2
        mk(1, -2000, 0, 0, 1,    7),
        mk(1, -1979, 1, 0, 1,    7),  // R5 clamp low, R8 blocked
        mk(1,  2000, 1, 0, 1,    7),
        mk(1,  1979, 0, 1, 1,    0),
        mk(1,  1500, 0, 0, 1,    0),
        mk(1,  1521, 1, 1, 1,  511),  // R5 clamp high
        mk(1, -1000, 0, 0, 1,  511),  // R8 equal value not applied
        mk(1, -2048, 0, 0, 1,  511),
        mk(1, -2027, 1, 0, 1,  511),
        mk(1, -1900, 1, 0, 1,  511),
        mk(1, -1921, 0, 1, 1, -512),  // R5 clamp low applied
        mk(1, -1850, 1, 0, 1, -512)   // R5 floor of odd negative, clamped equal
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(bit g, logic signed [11:0] s);
        gain_sel = g;
        smp      = s;
        smp_vld  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        smp_vld = 1'b0;
        chk("R9 strobe not early", int'(ofs_upd), 0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_reset_state(string tag);
        chk({tag, " R1 word"}, int'(ofs_word), 0);
        chk({tag, " R1 strobe"}, int'(ofs_upd), 0);
        chk({tag, " R1 cal"}, int'(calibrated), 0);
        chk({tag, " R1 slope"}, int'(slope_up), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after release");

        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] e;
            e = TBL[i];
            apply(e[25], e[24:13]);
            chk($sformatf("R4 slope vec%0d", i), int'(slope_up), int'(e[12]));
            chk($sformatf("R9 strobe vec%0d", i), int'(ofs_upd), int'(e[11]));
            chk($sformatf("R7 cal vec%0d", i), int'(calibrated), int'(e[10]));
            chk($sformatf("R5 word vec%0d", i), int'(ofs_word), int'($signed(e[9:0])));
        end

        // R10: invalid samples must not touch outputs or the running peak
        gain_sel = 1'b1;
        for (int k = 0; k < 4; k++) begin
            smp = (k % 2 == 0) ? 12'sd2047 : -12'sd2048;
            @(negedge clk);
            chk("R10 slope held", int'(slope_up), 1);
            chk("R10 word held", int'(ofs_word), -512);
            chk("R10 no strobe", int'(ofs_upd), 0);
        end
        apply(1'b1, -12'sd1840);
        chk("R10 running peak untouched", int'(slope_up), 1);

        // R1 mid-run reset, then R2 threshold boundary with low noise
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset_state("mid-run");
        rst_n = 1'b1;
        @(negedge clk);
        apply(1'b0, 12'sd0);
        apply(1'b0, -12'sd10);
        chk("R2 equal diff ignored", int'(slope_up), 0);
        apply(1'b0, 12'sd1);
        chk("R2 R4 eleven counts rises", int'(slope_up), 1);
        apply(1'b1, -12'sd15);
        chk("R3 high noise holds slope", int'(slope_up), 1);
        apply(1'b0, -12'sd15);
        chk("R3 low noise confirms peak", int'(slope_up), 0);
        chk("R6 single extreme no word", int'(ofs_upd), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule